// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block sits on the receive side of an Ethernet MAC and decides, from the 48-bit destination address at the head of each frame, whether the frame is kept or dropped. The address arrives one octet per cycle, in the order it appears on the wire. A CRC-32 accumulator runs alongside the octets and folds in each one as it arrives. The first octet of a frame is marked with a start strobe, and gaps between octets are allowed.

After the sixth octet, the block chooses one rule by the kind of address:
- An individual address is accepted only when it equals the programmed station address.
- The broadcast address (all ones) is always accepted.
- Any other group address is accepted when its entry in a 512-entry single-bit hash table is set.

A promiscuous setting overrides all of these rules and accepts every frame.

Software programs the hash table one entry per write. Each write is a control word that carries the entry index and a set/clear flag. A separate write port turns promiscuous mode on or off. The decision appears as a one-cycle valid pulse with an accept bit. It is registered at the edge that samples the sixth octet.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, all table entries are clear, promiscuous mode is off and `dec_valid` is low. With these settings, a group address that is not broadcast is rejected.
- R2: A pulse on `tbl_wr` writes exactly one table entry. Bits [8:0] of `tbl_word` give the entry index. Bit 9 writes 1 (set) or 0 (clear). No other entry changes.
- R3: The hash index is computed as follows:
  - Run a reflected CRC-32 over the six octets in wire order, each octet taken LSB first.
  - The polynomial is 0xEDB88320, the start value is all ones, and there is no final inversion.
  - Bit-reverse the 32-bit result and take bits [31:23] of the reversed value. So index bit 8 is CRC bit 0 and index bit 0 is CRC bit 8.
- R4: An address whose first octet has bit 0 equal to 1, and which is not broadcast, is accepted exactly when its table entry is set.
- R5: An address whose first octet has bit 0 equal to 0 is accepted exactly when it matches the station address. The table is never consulted for such an address. Octets 0 to 3 map to `stn_lo` bits [7:0], [15:8], [23:16] and [31:24]. Octets 4 and 5 map to `stn_hi` bits [7:0] and [15:8].
- R6: While promiscuous mode is on, every address is accepted. A pulse on `prom_wr` loads `prom_val` into the mode.
- R7: The all-ones broadcast address is accepted even when its table entry is clear.
- R8: `dec_valid` is high for exactly one cycle, at the clock edge after the edge that samples the sixth valid octet. Idle cycles between octets are allowed. `oct_sof` restarts address collection at the octet it accompanies.
- R9: If a table write and the sixth octet of a lookup fall in the same cycle, the lookup uses the entry value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| oct_valid | input | 1 | An address octet is present on `oct_data` |
| oct_sof | input | 1 | Marks the first octet of a destination address |
| oct_data | input | 8 | Destination address octet, in wire order |
| stn_lo | input | 32 | Station address, octets 0 to 3 |
| stn_hi | input | 16 | Station address, octets 4 and 5 |
| prom_wr | input | 1 | Load strobe for the promiscuous mode |
| prom_val | input | 1 | New promiscuous mode value |
| tbl_wr | input | 1 | Table write strobe |
| tbl_word | input | 10 | Table control word: [9] set/clear, [8:0] entry index |
| dec_valid | output | 1 | One-cycle pulse marking a decision |
| dec_accept | output | 1 | Accept (1) or reject (0), valid with `dec_valid` |

## Verification
The bench drives the following address kinds against a model table:
- the station address itself;
- a foreign individual address whose own hash entry has been set, which shows that individual addresses never reach the table;
- the broadcast address with its entry clear;
- two multicast addresses, whose outcomes differ as their entries are set and cleared.

Promiscuous mode is switched on and then off again to show that it overrides every other rule.

Octets are sent both back to back and with idle gaps, and one frame is abandoned partway and restarted with `oct_sof`. These cases separate correct octet counting from simple cycle counting.

In one case, a table write lands in the same cycle as a lookup of the same entry. The expected result shows which of the two is applied first.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
   localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

   // One octet through a reflected CRC-32, least significant bit first.
   function automatic logic [31:0] crc_octet(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int b = 0; b < 8; b++) begin
         if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
         else             r = r >> 1;
      end
      return r;
   endfunction

   function automatic logic [31:0] rev32(input logic [31:0] v);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = v[31 - i];
      return r;
   endfunction

endpackage

// File: rtl/mhf_addr_collect.sv
module mhf_addr_collect
   import mhf_pkg::*;
#(
   parameter int OCTETS = 6
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  oct_valid,
   input  logic                  oct_sof,
   input  logic [7:0]            oct_data,
   output logic                  last,
   output logic [8*OCTETS-1:0]   full_addr,
   output logic [31:0]           crc_fin
);
   localparam int CNT_W = (OCTETS > 1) ? $clog2(OCTETS) : 1;
   localparam int ADR_W = 8 * OCTETS;
   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(OCTETS - 1);

   if (OCTETS < 2) begin : g_bad_octets
      $error("mhf_addr_collect: OCTETS must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] pos;
   logic [31:0]      crc_q;
   logic [31:0]      crc_in;
   logic [ADR_W-1:0] sr_q;

   assign pos       = oct_sof ? '0 : cnt_q;
   assign crc_in    = (pos == '0) ? CRC_SEED : crc_q;
   assign crc_fin   = crc_octet(crc_in, oct_data);
   assign last      = oct_valid && (pos == LAST_POS);
   assign full_addr = {oct_data, sr_q[ADR_W-1:8]};

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         crc_q <= CRC_SEED;
         sr_q  <= '0;
      end else if (oct_valid) begin
         crc_q <= crc_fin;
         sr_q  <= full_addr;
         cnt_q <= (pos == LAST_POS) ? '0 : pos + 1'b1;
      end
   end

   // R8: the octet position never leaves the address length
   a_r8_pos_bound: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST_POS);
   // R8: a start strobe always restarts collection at the second position
   a_r8_sof_restart: assert property (@(posedge clk) disable iff (rst)
      (oct_valid && oct_sof) |=> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
   parameter int HASH_BITS = 9,
   parameter int WORD_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_en,
   input  logic                 wr_set,
   input  logic [HASH_BITS-1:0] wr_idx,
   input  logic [HASH_BITS-1:0] rd_idx,
   output logic                 rd_bit
);
   localparam int ENTRIES = 1 << HASH_BITS;
   localparam int SEL_W   = $clog2(WORD_W);
   localparam int WORDS   = ENTRIES / WORD_W;

   if ((1 << SEL_W) != WORD_W || SEL_W >= HASH_BITS) begin : g_bad_geom
      $error("mhf_hash_table: WORD_W must be a power of two below the table size");
   end

   logic [ENTRIES-1:0] tbl_flat;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      logic              hit;
      assign hit = wr_en && ((wr_idx >> SEL_W) == HASH_BITS'(w));
      always_ff @(posedge clk) begin
         if (rst)      word_q <= '0;
         else if (hit) word_q[wr_idx[SEL_W-1:0]] <= wr_set;
      end
      assign tbl_flat[w*WORD_W +: WORD_W] = word_q;
   end

   // Read from the flops: a write in the same cycle is not yet visible (R9).
   assign rd_bit = tbl_flat[rd_idx];

   // R2: a write leaves the addressed entry at the requested value
   a_r2_set_lands: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (tbl_flat[$past(wr_idx)] == $past(wr_set)));
   // R2: at most one entry changes per write
   a_r2_one_entry: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> ($countones(tbl_flat ^ $past(tbl_flat)) <= 1));
   // R2: without a write the table holds
   a_r2_hold: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(tbl_flat));

endmodule

// File: rtl/mhf_decide.sv
module mhf_decide #(
   parameter int ADR_W = 48
) (
   input  logic [ADR_W-1:0] addr,
   input  logic [31:0]      stn_lo,
   input  logic [15:0]      stn_hi,
   input  logic             promisc,
   input  logic             hash_hit,
   output logic             is_group,
   output logic             stn_match,
   output logic             accept
);
   if (ADR_W != 48) begin : g_bad_width
      $error("mhf_decide: station compare is built for 48-bit addresses");
   end

   logic is_bcast;

   assign is_group  = addr[0];
   assign is_bcast  = &addr;
   assign stn_match = (addr == {stn_hi, stn_lo});

   always_comb begin
      if (promisc)       accept = 1'b1;
      else if (is_bcast) accept = 1'b1;
      else if (is_group) accept = hash_hit;
      else               accept = stn_match;
   end

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
   import mhf_pkg::*;
#(
   parameter int HASH_BITS = 9,
   parameter int WORD_W    = 32,
   parameter int OCTETS    = 6
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 oct_valid,
   input  logic                 oct_sof,
   input  logic [7:0]           oct_data,
   input  logic [31:0]          stn_lo,
   input  logic [15:0]          stn_hi,
   input  logic                 prom_wr,
   input  logic                 prom_val,
   input  logic                 tbl_wr,
   input  logic [HASH_BITS:0]   tbl_word,
   output logic                 dec_valid,
   output logic                 dec_accept
);
   localparam int ADR_W = 8 * OCTETS;

   if (HASH_BITS < 6 || HASH_BITS > 12) begin : g_bad_hash
      $error("mcast_hash_filter: HASH_BITS out of range");
   end

   logic             last;
   logic [ADR_W-1:0] full_addr;
   logic [31:0]      crc_fin;
   logic [31:0]      crc_rev;
   logic [HASH_BITS-1:0] hidx;
   logic             hash_hit;
   logic             is_group;
   logic             stn_match;
   logic             accept_c;
   logic             prom_q;

   mhf_addr_collect #(.OCTETS(OCTETS)) u_collect (
      .clk       (clk),
      .rst       (rst),
      .oct_valid (oct_valid),
      .oct_sof   (oct_sof),
      .oct_data  (oct_data),
      .last      (last),
      .full_addr (full_addr),
      .crc_fin   (crc_fin)
   );

   assign crc_rev = rev32(crc_fin);
   assign hidx    = crc_rev[31 -: HASH_BITS];

   mhf_hash_table #(.HASH_BITS(HASH_BITS), .WORD_W(WORD_W)) u_table (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (tbl_wr),
      .wr_set (tbl_word[HASH_BITS]),
      .wr_idx (tbl_word[HASH_BITS-1:0]),
      .rd_idx (hidx),
      .rd_bit (hash_hit)
   );

   mhf_decide #(.ADR_W(ADR_W)) u_decide (
      .addr      (full_addr),
      .stn_lo    (stn_lo),
      .stn_hi    (stn_hi),
      .promisc   (prom_q),
      .hash_hit  (hash_hit),
      .is_group  (is_group),
      .stn_match (stn_match),
      .accept    (accept_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         prom_q     <= 1'b0;
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
      end else begin
         if (prom_wr) prom_q <= prom_val;
         dec_valid  <= last;
         dec_accept <= last && accept_c;
      end
   end

   // R8: a decision follows the sixth octet at the next edge
   a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
      last |=> dec_valid);
   // R8: no decision without a completed address
   a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !last |=> !dec_valid);
   // R6: promiscuous mode accepts every frame
   a_r6_promisc_accepts: assert property (@(posedge clk) disable iff (rst)
      (last && prom_q) |=> dec_accept);
   // R7: broadcast accepted regardless of the table
   a_r7_bcast_accepts: assert property (@(posedge clk) disable iff (rst)
      (last && (&full_addr)) |=> dec_accept);
   // R5: individual addresses follow the station compare only
   a_r5_individual: assert property (@(posedge clk) disable iff (rst)
      (last && !is_group && !prom_q) |=> (dec_accept == $past(stn_match)));

endmodule

// File: tb/tb_mcast_hash_filter.sv
module tb_mcast_hash_filter;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        oct_valid = 1'b0;
   logic        oct_sof = 1'b0;
   logic [7:0]  oct_data = '0;
   logic [31:0] stn_lo = 32'h3322_1102;
   logic [15:0] stn_hi = 16'h5544;
   logic        prom_wr = 1'b0;
   logic        prom_val = 1'b0;
   logic        tbl_wr = 1'b0;
   logic [9:0]  tbl_word = '0;
   logic        dec_valid;
   logic        dec_accept;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic [511:0] m_tbl = '0;
   logic         m_prom = 1'b0;
   bit           exp_q[$];
   string        tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   mcast_hash_filter dut (
      .clk(clk), .rst(rst), .oct_valid(oct_valid), .oct_sof(oct_sof),
      .oct_data(oct_data), .stn_lo(stn_lo), .stn_hi(stn_hi),
      .prom_wr(prom_wr), .prom_val(prom_val), .tbl_wr(tbl_wr),
      .tbl_word(tbl_word), .dec_valid(dec_valid), .dec_accept(dec_accept)
   );

   // R3 reference: serial reflected CRC, then index bit 8-k = CRC bit k
   function automatic logic [8:0] ref_idx(input logic [47:0] a);
      logic [31:0] c;
      logic [8:0]  ix;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < 6; i++)
         for (int b = 0; b < 8; b++) begin
            logic fb;
            fb = c[0] ^ a[8*i + b];
            c  = c >> 1;
            if (fb) c = c ^ 32'hEDB8_8320;
         end
      for (int k = 0; k < 9; k++) ix[8 - k] = c[k];
      return ix;
   endfunction

   function automatic logic [47:0] mk(input logic [7:0] o0, o1, o2, o3, o4, o5);
      return {o5, o4, o3, o2, o1, o0};
   endfunction

   function automatic bit ref_accept(input logic [47:0] a);
      if (m_prom)                  return 1'b1;
      if (a == 48'hFFFF_FFFF_FFFF) return 1'b1;
      if (a[0])                    return m_tbl[ref_idx(a)];
      return a == {stn_hi, stn_lo};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tbl_write(input logic [8:0] idx, input bit set);
      @(negedge clk);
      tbl_wr = 1'b1; tbl_word = {set, idx};
      @(negedge clk);
      tbl_wr = 1'b0;
      m_tbl[idx] = set;
   endtask

   task automatic set_prom(input bit v);
      @(negedge clk);
      prom_wr = 1'b1; prom_val = v;
      @(negedge clk);
      prom_wr = 1'b0;
      m_prom = v;
   endtask

   // Drives one address; optional table write in the cycle of the sixth octet.
   task automatic send(input logic [47:0] a, input int gap, input string req,
                       input bit coll, input logic [9:0] coll_word);
      bit e;
      e = ref_accept(a);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         oct_valid = 1'b1; oct_sof = (i == 0); oct_data = a[8*i +: 8];
         if (i == 5) begin
            exp_q.push_back(e);
            tag_q.push_back(req);
            if (coll) begin tbl_wr = 1'b1; tbl_word = coll_word; end
         end
         if (i < 5)
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               oct_valid = 1'b0; oct_sof = 1'b0;
            end
      end
      @(negedge clk);
      oct_valid = 1'b0; oct_sof = 1'b0; tbl_wr = 1'b0;
      if (coll) m_tbl[coll_word[8:0]] = coll_word[9];
   endtask

   task automatic send_partial(input logic [47:0] a, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         oct_valid = 1'b1; oct_sof = (i == 0); oct_data = a[8*i +: 8];
      end
      @(negedge clk);
      oct_valid = 1'b0; oct_sof = 1'b0;
   endtask

   // Monitor: the scoreboard entry must be answered at the very next edge (R8).
   always @(posedge clk) begin
      #1;
      if (!rst) begin
         if (dec_valid) begin
            if (exp_q.size() == 0) begin
               check("R8 pulse without frame", 1, 0);
            end else begin
               bit e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check({t, " accept"}, dec_accept, e);
            end
         end else if (exp_q.size() != 0) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
            check("R8 decision missing", 0, 1);
         end
      end
   end

   initial begin
      logic [47:0] stn, other, grpa, grpb, bcast;
      stn   = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
      other = mk(8'h00, 8'h1b, 8'h21, 8'h9a, 8'hc4, 8'h07);
      grpa  = mk(8'h01, 8'h00, 8'h5e, 8'h00, 8'h00, 8'h01);
      grpb  = mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h01);
      bcast = 48'hFFFF_FFFF_FFFF;

      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1 valid low after reset", dec_valid, 0);

      send(grpa,  0, "R1 empty table rejects group", 0, '0);
      send(stn,   0, "R5 station match", 0, '0);
      send(other, 0, "R5 foreign individual", 0, '0);
      tbl_write(ref_idx(other), 1'b1);
      send(other, 0, "R5 table ignored for individual", 0, '0);
      send(bcast, 0, "R7 broadcast with clear entry", 0, '0);
      tbl_write(ref_idx(grpa), 1'b1);
      send(grpa,  0, "R3 R4 hashed group accepted", 0, '0);
      send(grpb,  1, "R3 R4 other group", 0, '0);
      tbl_write(ref_idx(grpb), 1'b1);
      send(grpb,  2, "R2 R4 second entry set", 0, '0);
      tbl_write(ref_idx(grpa), 1'b0);
      send(grpa,  0, "R2 entry cleared", 0, '0);
      send(grpb,  0, "R2 neighbour entry kept", 0, '0);
      set_prom(1'b1);
      send(grpa,  0, "R6 promiscuous group", 0, '0);
      send(other, 3, "R6 promiscuous individual", 0, '0);
      set_prom(1'b0);
      send(grpa,  0, "R6 promiscuous off", 0, '0);
      send_partial(stn, 3);
      send(grpb,  0, "R8 sof restart", 0, '0);
      send(grpa,  0, "R9 write in lookup cycle sees old", 1, {1'b1, ref_idx(grpa)});
      send(grpa,  0, "R9 write visible next frame", 0, '0);
      for (int k = 0; k < 6; k++) begin
         logic [47:0] g;
         g = mk(8'h01 | 8'(k << 1), 8'h5e, 8'(k * 37), 8'h10, 8'(k), 8'hA5);
         if (k % 2 == 0) tbl_write(ref_idx(g), 1'b1);
         send(g, k % 3, "R3 R4 sweep", 0, '0);
      end
      repeat (3) @(negedge clk);
      check("R8 scoreboard drained", exp_q.size(), 0);
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule